// File: doc/BRIEF.md
# Shared PCI Bus Arbiter with Ownership Timeslice

This block decides which agent may drive a shared PCI bus. Seven agents compete. Five general masters each use an active-low request and grant pair. An I/O bridge agent requests with an active-low hold input and is answered on an active-low acknowledge output. The host bridge's own master raises an active-high request only while it has an outbound transaction to run. The arbiter hands the bus to one agent at a time. The order rotates, so every requester is served in turn.

Ownership changes only while the bus is idle, that is while `frame_n` and `irdy_n` are both high. Each new grant loads a countdown from `slice_len`. While the count is running, the owner may string several transactions together, even with others waiting. When nobody else asks for the bus, a general master or the host keeps its grant. The I/O bridge is never left holding the bus. An active `lock_n` freezes ownership for an exclusive sequence. Between two different owners there is always one clock in which no grant is active.

Top module: `pci_timeslice_arbiter`

## Requirements
- R1: During and straight after reset, `host_gnt` is 1, every bit of `gnt_n` is 1 and `hold_ack_n` is 1.
- R2: In every cycle at most one of the seven grant indications is active.
- R3: When ownership passes from one agent to another, exactly one cycle with no active grant lies between the two grants.
- R4: Slots are numbered 0 to 4 for masters `req_n[0]` to `req_n[4]`, 5 for the I/O bridge (`hold_n`) and 6 for the host (`host_req`). A new grant goes to the first requesting slot in ascending cyclic order, starting one past the last owner.
- R5: An owner other than the I/O bridge keeps its grant while no other slot requests. This holds even if the owner has withdrawn its own request.
- R6: The edge after the bridge withdraws `hold_n` on an idle, unlocked bus, `hold_ack_n` goes high. If nothing is pending, the host is granted one cycle later.
- R7: On every new grant the countdown loads `slice_len`. If the owner keeps requesting while another slot waits, the owner keeps the bus for exactly `slice_len`+1 cycles before the idle cycle.
- R8: An owner that withdraws its request while another slot waits loses its grant at the next idle edge, even if its countdown has not run out.
- R9: While `frame_n` or `irdy_n` is low, no grant output changes.
- R10: While `lock_n` is low and a grant is active, that grant does not change, whatever requests or countdown state exist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | PCI clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_n | input | 5 | Active-low requests of the general masters |
| gnt_n | output | 5 | Active-low grants to the general masters |
| hold_n | input | 1 | Active-low hold request of the I/O bridge |
| hold_ack_n | output | 1 | Active-low acknowledge to the I/O bridge |
| host_req | input | 1 | Host bridge master wants the bus |
| host_gnt | output | 1 | Host bridge master owns the bus |
| frame_n | input | 1 | Bus FRAME, low while a transaction is in progress |
| irdy_n | input | 1 | Bus IRDY, low while the initiator is ready |
| lock_n | input | 1 | Low while an exclusive sequence holds the bus |
| slice_len | input | 8 | Programmed ownership window in clocks |

## Verification
Two decisions can fall in the same cycle: countdown expiry with another slot waiting, and a busy bus (`frame_n` low) or an active `lock_n`. The bench lets the countdown run out while it holds `frame_n` low, and later while it holds `lock_n` low. It expects the grant to stay put during that time. It then expects exactly one idle cycle and a grant to the next slot on the edges after the freeze is released. In the second case, the end of the window and the owner's own withdrawal meet the rotation. For every one of the 127 request masks, the bench computes the next owner from the last observed owner, with the countdown at zero.

// File: rtl/pci_arb_pkg.sv
package pci_arb_pkg;
   // slot offsets above the general masters
   localparam int unsigned BRIDGE_OFS = 0;
   localparam int unsigned HOST_OFS   = 1;
   localparam int unsigned EXTRA_SLOTS = 2;

   typedef enum logic [1:0] {
      KEEP_OWNER = 2'd0,
      RELEASE    = 2'd1,
      NEW_GRANT  = 2'd2
   } arb_step_e;
endpackage

// File: rtl/rr_slot_picker.sv
module rr_slot_picker #(
   parameter int unsigned N_SLOTS = 7,
   localparam int unsigned IW = $clog2(N_SLOTS)
) (
   input  logic [N_SLOTS-1:0] req,
   input  logic [IW-1:0]      last,
   output logic               found,
   output logic [IW-1:0]      pick
);
   always_comb begin
      int idx;
      found = 1'b0;
      pick  = '0;
      idx   = 0;
      for (int off = 1; off <= int'(N_SLOTS); off++) begin
         idx = (int'(last) + off) % int'(N_SLOTS);
         if (!found && req[idx]) begin
            found = 1'b1;
            pick  = IW'(idx);
         end
      end
   end
endmodule

// File: rtl/own_slice_timer.sv
module own_slice_timer #(
   parameter int unsigned TW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);
   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= '0;
      else if (load)          cnt_q <= load_val;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);
endmodule

// File: rtl/pci_timeslice_arbiter.sv
module pci_timeslice_arbiter
   import pci_arb_pkg::*;
#(
   parameter int unsigned N_MASTERS = 5,
   parameter int unsigned TW        = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_MASTERS-1:0] req_n,
   output logic [N_MASTERS-1:0] gnt_n,
   input  logic                 hold_n,
   output logic                 hold_ack_n,
   input  logic                 host_req,
   output logic                 host_gnt,
   input  logic                 frame_n,
   input  logic                 irdy_n,
   input  logic                 lock_n,
   input  logic [TW-1:0]        slice_len
);
   localparam int unsigned N_SLOTS = N_MASTERS + EXTRA_SLOTS;
   localparam int unsigned IW      = $clog2(N_SLOTS);
   localparam int unsigned BRIDGE  = N_MASTERS + BRIDGE_OFS;
   localparam int unsigned HOST    = N_MASTERS + HOST_OFS;

   if (N_MASTERS < 1) begin : g_bad_masters
      $error("pci_timeslice_arbiter: N_MASTERS must be at least 1");
   end
   if (TW < 1 || TW > 16) begin : g_bad_tw
      $error("pci_timeslice_arbiter: TW must be 1..16");
   end

   logic [N_SLOTS-1:0] req;
   logic [N_SLOTS-1:0] own_bit;
   logic [N_SLOTS-1:0] gv;
   logic               granted_q, granted_d;
   logic [IW-1:0]      owner_q, owner_d;
   logic               found, expired, others, owner_req, bus_idle;
   logic [IW-1:0]      pick;
   arb_step_e          step;

   // request vector, slot order fixed by the rotation
   for (genvar i = 0; i < int'(N_MASTERS); i++) begin : g_req
      assign req[i] = ~req_n[i];
   end
   assign req[BRIDGE] = ~hold_n;
   assign req[HOST]   = host_req;

   assign own_bit   = {{(N_SLOTS-1){1'b0}}, 1'b1} << owner_q;
   assign others    = |(req & ~own_bit);
   assign owner_req = |(req & own_bit);
   assign bus_idle  = frame_n & irdy_n;

   rr_slot_picker #(.N_SLOTS(N_SLOTS)) u_pick (
      .req   (req),
      .last  (owner_q),
      .found (found),
      .pick  (pick)
   );

   own_slice_timer #(.TW(TW)) u_slice (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (step == NEW_GRANT),
      .load_val (slice_len),
      .expired  (expired)
   );

   always_comb begin
      step = KEEP_OWNER;
      if (bus_idle) begin
         if (!granted_q) begin
            step = NEW_GRANT;
         end else if (lock_n) begin
            if (owner_q == IW'(BRIDGE)) begin
               if (!owner_req || (others && expired)) step = RELEASE;
            end else if (others && (expired || !owner_req)) begin
               step = RELEASE;
            end
         end
      end
   end

   always_comb begin
      granted_d = granted_q;
      owner_d   = owner_q;
      unique case (step)
         RELEASE:   granted_d = 1'b0;
         NEW_GRANT: begin
            granted_d = 1'b1;
            owner_d   = found ? pick : IW'(HOST);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         granted_q <= 1'b1;
         owner_q   <= IW'(HOST);
      end else begin
         granted_q <= granted_d;
         owner_q   <= owner_d;
      end
   end

   assign gv = granted_q ? own_bit : '0;

   for (genvar i = 0; i < int'(N_MASTERS); i++) begin : g_gnt
      assign gnt_n[i] = ~gv[i];
   end
   assign hold_ack_n = ~gv[BRIDGE];
   assign host_gnt   = gv[HOST];
endmodule

// File: rtl/pci_arb_checker.sv
module pci_arb_checker #(
   parameter int unsigned N_MASTERS = 5
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [N_MASTERS-1:0] req_n,
   input logic [N_MASTERS-1:0] gnt_n,
   input logic                 hold_n,
   input logic                 hold_ack_n,
   input logic                 host_req,
   input logic                 host_gnt,
   input logic                 frame_n,
   input logic                 irdy_n,
   input logic                 lock_n
);
   logic [N_MASTERS+1:0] gv, rv;
   assign gv = {host_gnt, ~hold_ack_n, ~gnt_n};
   assign rv = {host_req, ~hold_n, ~req_n};

   a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(gv));

   a_r3_idle_gap: assert property (@(posedge clk) disable iff (!rst_n)
      (gv != '0 && $past(gv) != '0) |-> gv == $past(gv));

   a_r5_park: assert property (@(posedge clk) disable iff (!rst_n)
      (gv != '0 && hold_ack_n && (rv & ~gv) == '0) |=> $stable(gv));

   a_r6_bridge_release: assert property (@(posedge clk) disable iff (!rst_n)
      (!hold_ack_n && hold_n && frame_n && irdy_n && lock_n) |=> hold_ack_n);

   a_r9_busy_freeze: assert property (@(posedge clk) disable iff (!rst_n)
      (!frame_n || !irdy_n) |=> $stable(gv));

   a_r10_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!lock_n && gv != '0) |=> $stable(gv));
endmodule

bind pci_timeslice_arbiter pci_arb_checker #(.N_MASTERS(N_MASTERS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_n      (req_n),
   .gnt_n      (gnt_n),
   .hold_n     (hold_n),
   .hold_ack_n (hold_ack_n),
   .host_req   (host_req),
   .host_gnt   (host_gnt),
   .frame_n    (frame_n),
   .irdy_n     (irdy_n),
   .lock_n     (lock_n)
);

// File: tb/pci_timeslice_arbiter_tb.sv
`timescale 1ns/1ps
module pci_timeslice_arbiter_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] req_n = 5'h1f;
   logic [4:0] gnt_n;
   logic       hold_n = 1'b1;
   logic       hold_ack_n;
   logic       host_req = 1'b0;
   logic       host_gnt;
   logic       frame_n = 1'b1;
   logic       irdy_n = 1'b1;
   logic       lock_n = 1'b1;
   logic [7:0] slice_len = 8'd0;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   pci_timeslice_arbiter u_dut (
      .clk(clk), .rst_n(rst_n), .req_n(req_n), .gnt_n(gnt_n),
      .hold_n(hold_n), .hold_ack_n(hold_ack_n), .host_req(host_req),
      .host_gnt(host_gnt), .frame_n(frame_n), .irdy_n(irdy_n),
      .lock_n(lock_n), .slice_len(slice_len)
   );

   // -1 none, 0..6 slot, 99 more than one
   function automatic int owner();
      logic [6:0] g;
      int o;
      g = {host_gnt, ~hold_ack_n, ~gnt_n};
      if ($countones(g) > 1) return 99;
      o = -1;
      for (int i = 0; i < 7; i++) if (g[i]) o = i;
      return o;
   endfunction

   function automatic int rr_next(input logic [6:0] m, input int last);
      for (int off = 1; off <= 7; off++)
         if (m[(last + off) % 7]) return (last + off) % 7;
      return 6;
   endfunction

   task automatic chk(input string rq, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   task automatic set_mask(input logic [6:0] m);
      req_n    = ~m[4:0];
      hold_n   = ~m[5];
      host_req = m[6];
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int cnt, p, prev, cur;
      repeat (3) @(negedge clk);
      chk("R1 owner in reset", owner(), 6);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 owner after reset", owner(), 6);

      // host parked with no requests
      repeat (4) @(negedge clk);
      chk("R5 host parked", owner(), 6);

      // master 2 takes the bus through an idle cycle
      req_n[2] = 1'b0;
      @(negedge clk); chk("R3 idle before master 2", owner(), -1);
      @(negedge clk); chk("R4 grant to master 2", owner(), 2);
      req_n[2] = 1'b1;
      repeat (3) @(negedge clk);
      chk("R5 master 2 parked after release", owner(), 2);

      // R7 window length
      slice_len = 8'd4;
      req_n[0] = 1'b0; req_n[2] = 1'b0;
      @(negedge clk); chk("R3 idle before master 0", owner(), -1);
      @(negedge clk);
      cnt = 0;
      while (owner() == 0 && cnt < 50) begin cnt++; @(negedge clk); end
      chk("R7 window cycles", cnt, 5);
      chk("R3 idle after window", owner(), -1);
      @(negedge clk); chk("R4 rotation back to master 2", owner(), 2);

      // R8 early withdrawal
      req_n[2] = 1'b1;
      @(negedge clk); chk("R8 early release", owner(), -1);
      @(negedge clk); chk("R8 waiting master granted", owner(), 0);
      req_n[0] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 master 0 parked", owner(), 0);

      // R9 busy bus holds ownership past expiry
      slice_len = 8'd2;
      frame_n = 1'b0; req_n[3] = 1'b0;
      for (int k = 0; k < 6; k++) begin
         @(negedge clk); chk("R9 frozen while busy", owner(), 0);
      end
      frame_n = 1'b1;
      @(negedge clk); chk("R9 release after idle", owner(), -1);
      @(negedge clk); chk("R4 grant to master 3", owner(), 3);

      // R10 lock holds ownership past expiry
      req_n[1] = 1'b0; lock_n = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); chk("R10 locked owner kept", owner(), 3);
      end
      lock_n = 1'b1;
      @(negedge clk); chk("R10 release after unlock", owner(), -1);
      @(negedge clk); chk("R4 grant to master 1", owner(), 1);
      req_n[1] = 1'b1; req_n[3] = 1'b1;
      repeat (2) @(negedge clk);
      chk("R5 master 1 parked", owner(), 1);

      // R6 bridge handshake and no parking
      hold_n = 1'b0;
      @(negedge clk); chk("R3 idle before bridge", owner(), -1);
      @(negedge clk); chk("R6 bridge acknowledged", int'(hold_ack_n), 0);
      repeat (3) @(negedge clk);
      chk("R6 bridge kept while holding", owner(), 5);
      hold_n = 1'b1;
      @(negedge clk); chk("R6 acknowledge removed", int'(hold_ack_n), 1);
      chk("R6 no grant after bridge", owner(), -1);
      @(negedge clk); chk("R6 host regains bus", owner(), 6);

      // R4 sweep over every request mask with zero window
      slice_len = 8'd0;
      p = owner();
      for (int m = 1; m < 128; m++) begin
         prev = owner();
         set_mask(7'(m));
         for (int c = 0; c < 21; c++) begin
            @(negedge clk);
            cur = owner();
            if (cur == 99) chk("R2 multiple grants", cur, -1);
            if (prev == -1 && cur >= 0) begin
               chk("R4 rotation order", cur, rr_next(7'(m), p));
               p = cur;
            end
            if (prev >= 0 && cur >= 0 && cur != prev)
               chk("R3 missing idle cycle", cur, -1);
            prev = cur;
         end
      end
      set_mask(7'd0);
      repeat (4) @(negedge clk);
      summary();
      $finish;
   end
endmodule